// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block generates the processor reset and the watchdog fault signal for a power supervisor. It takes a supply-good flag that the analog threshold comparison has already produced, synchronous to `clk`. Reset is asserted while that flag is low or while the active-low manual reset pin is held low. When both conditions clear, reset stays asserted for a fixed stretch of clock cycles. The manual reset pin and the watchdog kick input are asynchronous. Each passes through a two-flop synchronizer. The manual reset pin then goes through a cycle-count debounce filter that rejects short glitches.

The watchdog counts the cycles since the last edge on `wdi`. A rising or a falling edge restarts the count, and so does any cycle in which reset is asserted. The watchdog is idle when `wd_present` is low (kick input left unconnected) or when `batt_mode` is high (battery backup). When the count expires, `wd_pulse_mode` selects what happens:
- In pulse mode, the expiry triggers a full reset stretch.
- In output mode, the expiry sets a fault flag on `wdo_n` that holds until the next kick edge or the next reset.

All timing is set by parameters in clock cycles: `RST_CYC` (reset stretch), `WD_CYC` (watchdog timeout) and `MR_FILT_CYC` (manual reset filter).

Top module: `sup_reset_ctrl`

## Requirements
- R1: A cycle with `supply_ok` low is followed one clock edge later by `reset_n` low.
- R2: `reset_n` returns high exactly `RST_CYC` clock edges after the last edge that sampled the reset hold condition (supply low, filtered manual reset low, or watchdog pulse request).
- R3: A low run on `mr_n` of fewer than `MR_FILT_CYC` sampled cycles never asserts reset. A run of at least `MR_FILT_CYC` cycles drives `reset_n` low `MR_FILT_CYC`+3 edges after `mr_n` falls. `reset_n` returns high `MR_FILT_CYC`+2+`RST_CYC` edges after `mr_n` rises.
- R4: A kick edge on `wdi` of either polarity restarts the watchdog. Kicks spaced at most `WD_CYC` cycles apart never fault. With no further edge, the expiry occurs `WD_CYC`+3 edges after the last `wdi` change.
- R5: In output mode (`wd_pulse_mode`=0), expiry drives `wdo_n` low. `wdo_n` stays low until a `wdi` edge, which raises it 3 edges after the `wdi` change.
- R6: Any reset assertion clears the watchdog fault: `wdo_n` is high at the second edge after a supply drop.
- R7: In pulse mode (`wd_pulse_mode`=1), expiry drives `reset_n` low at the expiry edge for a full `RST_CYC` stretch, and `wdo_n` stays high.
- R8: The watchdog does not count while reset is asserted. Without kicks, the first expiry comes `WD_CYC` edges after `reset_n` rises.
- R9: With `wd_present`=0 or `batt_mode`=1, the watchdog never expires and `wdo_n` stays high.
- R10: `reset_hi` is always the complement of `reset_n`.
- R11: While `rst_n` is low, `reset_n`=0 and `wdo_n`=1. After `rst_n` is released, `reset_n` rises after exactly `RST_CYC` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block reset, active low |
| supply_ok | input | 1 | Supply above threshold, synchronous to clk |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wdi | input | 1 | Watchdog kick input, asynchronous |
| wd_present | input | 1 | 1 when the kick input is driven; 0 disables the watchdog |
| batt_mode | input | 1 | 1 in battery backup; disables the watchdog |
| wd_pulse_mode | input | 1 | 1: expiry pulses reset; 0: expiry drives wdo_n |
| reset_n | output | 1 | Processor reset, active low |
| reset_hi | output | 1 | Processor reset, active high |
| wdo_n | output | 1 | Watchdog fault output, active low |

## Verification
Supply drops of one, two and three cycles show that the stretch is timed from the last hold cycle and not from the drop itself. A sweep of manual reset pulse lengths across the filter limit marks where glitches stop being rejected, and measures both the assertion latency and the release latency. Kick spacings just below, at and one above the timeout show that an edge on the expiry cycle still wins. The bench also drives expiries in both modes, clears the fault once by a kick and once by a reset, and holds both disable inputs to confirm silence.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Width of a counter that must hold values 0..limit.
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Reset-stretch counter step: reload on hold, otherwise count down to zero.
  function automatic int unsigned stretch_step(input int unsigned cur,
                                               input bit hold,
                                               input int unsigned load);
    if (hold) return load;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // Watchdog expiry: the counter has reached its last idle cycle.
  function automatic bit wd_hit(input int unsigned cur, input int unsigned limit);
    return cur == (limit - 1);
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce
  import sup_pkg::*;
#(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic flip
);
  localparam int CW = cnt_bits(FILT_CYC);

  logic [CW-1:0] run_cnt;
  logic          differ;

  assign differ = raw ^ level;
  assign flip   = differ && (run_cnt == CW'(FILT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b1;
      run_cnt <= '0;
    end else if (!differ) begin
      run_cnt <= '0;
    end else if (flip) begin
      level   <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer
  import sup_pkg::*;
#(
  parameter int RST_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic rst_act
);
  localparam int CW = cnt_bits(RST_CYC);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb cnt_nxt = CW'(stretch_step(32'(cnt), hold, RST_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CW'(RST_CYC);
      rst_act <= 1'b1;
    end else begin
      cnt     <= cnt_nxt;
      rst_act <= hold | (cnt_nxt != '0);
    end
  end
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int WD_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_s,
  input  logic run,
  input  logic pulse_mode,
  output logic kick_edge,
  output logic expire,
  output logic fault
);
  localparam int WCW = cnt_bits(WD_CYC);

  logic [WCW-1:0] wcnt;
  logic           kick_prev;

  assign kick_edge = kick_s ^ kick_prev;
  assign expire    = run && !kick_edge && wd_hit(32'(wcnt), WD_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_prev <= 1'b0;
      wcnt      <= '0;
      fault     <= 1'b0;
    end else begin
      kick_prev <= kick_s;
      if (!run || kick_edge) begin
        wcnt  <= '0;
        fault <= 1'b0;
      end else if (expire) begin
        wcnt <= '0;
        if (!pulse_mode) fault <= 1'b1;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int MR_FILT_CYC = 4,
  parameter int RST_CYC     = 200,
  parameter int WD_CYC      = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wdi,
  input  logic wd_present,
  input  logic batt_mode,
  input  logic wd_pulse_mode,
  output logic reset_n,
  output logic reset_hi,
  output logic wdo_n
);
  logic mr_sync, mr_level, mr_flip;
  logic wdi_sync;
  logic hold_w, rst_act, wd_run_w;
  logic wd_edge_w, wd_expire_w, wd_fault;

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst_n(rst_n), .d(mr_n), .q(mr_sync)
  );

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wdi_sync (
    .clk(clk), .rst_n(rst_n), .d(wdi), .q(wdi_sync)
  );

  sup_debounce #(.FILT_CYC(MR_FILT_CYC)) u_mr_filt (
    .clk(clk), .rst_n(rst_n), .raw(mr_sync), .level(mr_level), .flip(mr_flip)
  );

  // Reset is held by a low supply, a filtered manual reset, or a watchdog pulse request
  assign hold_w   = !supply_ok || !mr_level || (wd_expire_w && wd_pulse_mode);
  assign wd_run_w = wd_present && !batt_mode && !rst_act;

  sup_rst_timer #(.RST_CYC(RST_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(hold_w), .rst_act(rst_act)
  );

  sup_watchdog #(.WD_CYC(WD_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .kick_s(wdi_sync), .run(wd_run_w),
    .pulse_mode(wd_pulse_mode), .kick_edge(wd_edge_w),
    .expire(wd_expire_w), .fault(wd_fault)
  );

  assign reset_n  = !rst_act;
  assign reset_hi = rst_act;
  assign wdo_n    = !wd_fault;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int RST_CYC = 200
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic reset_n,
  input logic wdo_n,
  input logic wd_present,
  input logic wd_pulse_mode,
  input logic hold_w,
  input logic expire_w
);
  localparam int GW = $clog2(RST_CYC + 2);
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap <= '0;
    else if (hold_w)                gap <= '0;
    else if (gap != GW'(RST_CYC+1)) gap <= gap + 1'b1;
  end

  // R1
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !reset_n);

  // R2
  stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> gap == GW'(RST_CYC));

  // R5
  fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdo_n) |-> ($past(expire_w) && !$past(wd_pulse_mode)));

  // R6
  reset_clears_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_n |=> wdo_n);

  // R7
  pulse_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && wd_pulse_mode) |=> !reset_n);

  // R9
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_present |-> !expire_w);
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .reset_n(reset_n),
  .wdo_n(wdo_n), .wd_present(wd_present), .wd_pulse_mode(wd_pulse_mode),
  .hold_w(hold_w), .expire_w(wd_expire_w)
);

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
  localparam int FILT = 3;
  localparam int RST  = 20;
  localparam int WD   = 40;

  logic clk = 1'b0;
  logic rst_n, supply_ok, mr_n, wdi, wd_present, batt_mode, wd_pulse_mode;
  logic reset_n, reset_hi, wdo_n;

  int tests = 0;
  int fails = 0;
  int cmp_bad = 0;
  bit cmp_on = 0;
  bit pulse_phase = 0;
  bit wdo_seen_low = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sup_reset_ctrl #(.SYNC_STAGES(2), .MR_FILT_CYC(FILT), .RST_CYC(RST), .WD_CYC(WD)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wdi(wdi),
    .wd_present(wd_present), .batt_mode(batt_mode), .wd_pulse_mode(wd_pulse_mode),
    .reset_n(reset_n), .reset_hi(reset_hi), .wdo_n(wdo_n)
  );

  // R10 monitor and pulse-mode wdo monitor
  always @(negedge clk) begin
    if (cmp_on && (reset_hi !== ~reset_n)) cmp_bad++;
    if (pulse_phase && wdo_n !== 1'b1) wdo_seen_low = 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wait_rst(input logic val, input int cap, output int n);
    n = 0;
    while (n < cap) begin
      @(posedge clk); n++; @(negedge clk);
      if (reset_n === val) return;
    end
    n = -1;
  endtask

  task automatic wait_wdo(input logic val, input int cap, output int n);
    n = 0;
    while (n < cap) begin
      @(posedge clk); n++; @(negedge clk);
      if (wdo_n === val) return;
    end
    n = -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, fall_t, rise_t;
    bit seen;
    rst_n = 0; supply_ok = 1; mr_n = 1; wdi = 0;
    wd_present = 1; batt_mode = 0; wd_pulse_mode = 0;
    step(5);
    // R11 reset state
    check(reset_n === 1'b0 && wdo_n === 1'b1, "R11 reset state", int'(reset_n), 0);
    check(reset_hi === 1'b1, "R10 reset_hi in block reset", int'(reset_hi), 1);
    rst_n = 1; cmp_on = 1;
    wait_rst(1'b1, 10*RST, n);
    check(n == RST, "R11 release after block reset", n, RST);

    // R1/R2 supply drops of several lengths
    for (int d = 1; d <= 3; d++) begin
      supply_ok = 0;
      step(1);
      check(reset_n === 1'b0, "R1 supply drop asserts", int'(reset_n), 0);
      step(d - 1);
      supply_ok = 1;
      wait_rst(1'b1, 10*RST, n);
      check(n == RST, "R2 stretch after supply", n, RST);
    end

    // R3 manual reset pulse length sweep
    for (int L = 1; L <= FILT + 2; L++) begin
      int t;
      fall_t = -1; rise_t = -1; t = 0;
      mr_n = 0;
      while (t < L + FILT + RST + 10) begin
        @(posedge clk); t++; @(negedge clk);
        if (fall_t < 0 && reset_n === 1'b0) fall_t = t;
        if (fall_t >= 0 && rise_t < 0 && reset_n === 1'b1) begin
          rise_t = t;
          break;
        end
        if (t == L) mr_n = 1;
      end
      if (L < FILT) begin
        check(fall_t == -1, "R3 short manual pulse ignored", fall_t, -1);
      end else begin
        check(fall_t == FILT + 3, "R3 manual reset latency", fall_t, FILT + 3);
        check(rise_t == L + FILT + 2 + RST, "R3 manual release stretch", rise_t, L + FILT + 2 + RST);
      end
    end

    // R4 expiry timing after a kick edge
    wdi = ~wdi;
    wait_wdo(1'b0, 3*WD, n);
    check(n == WD + 3, "R4 expiry after last kick", n, WD + 3);
    // R5 fault held until a kick edge
    step(WD / 2);
    check(wdo_n === 1'b0, "R5 fault held", int'(wdo_n), 0);
    wdi = ~wdi;
    wait_wdo(1'b1, 3*WD, n);
    check(n == 3, "R5 kick clears fault", n, 3);

    // R4 kick spacing sweep, both edge polarities
    for (int K = WD - 2; K <= WD + 1; K++) begin
      seen = 0;
      for (int k = 0; k < 4; k++) begin
        wdi = ~wdi;
        for (int c = 0; c < K; c++) begin
          @(posedge clk); @(negedge clk);
          if (wdo_n !== 1'b1) seen = 1;
        end
      end
      if (K <= WD) check(!seen, "R4 kicks within timeout", int'(seen), 0);
      else         check(seen, "R4 kicks past timeout fault", int'(seen), 1);
    end

    // R6 reset clears fault
    wait_wdo(1'b0, 3*WD, n);
    check(n > 0, "R6 fault before reset", n, 1);
    supply_ok = 0;
    step(1);
    supply_ok = 1;
    step(1);
    check(wdo_n === 1'b1, "R6 reset clears fault", int'(wdo_n), 1);
    // R8 count starts at reset release
    wait_rst(1'b1, 10*RST, n);
    wait_wdo(1'b0, 3*WD, n);
    check(n == WD, "R8 expiry after reset release", n, WD);

    // R9 watchdog absent, then battery mode
    wd_present = 0;
    seen = 0;
    for (int c = 0; c < 3*WD; c++) begin
      @(posedge clk); @(negedge clk);
      if (c > 2 && wdo_n !== 1'b1) seen = 1;
    end
    check(!seen && wdo_n === 1'b1, "R9 absent watchdog quiet", int'(seen), 0);
    wd_present = 1; batt_mode = 1;
    seen = 0;
    for (int c = 0; c < 3*WD; c++) begin
      @(posedge clk); @(negedge clk);
      if (wdo_n !== 1'b1) seen = 1;
    end
    check(!seen, "R9 battery mode quiet", int'(seen), 0);
    batt_mode = 0;

    // R7 pulse mode
    supply_ok = 0; wd_pulse_mode = 1;
    step(1);
    supply_ok = 1;
    pulse_phase = 1;
    wait_rst(1'b1, 10*RST, n);
    for (int p = 0; p < 2; p++) begin
      wait_rst(1'b0, 3*WD, n);
      check(n == WD, "R7 pulse after expiry", n, WD);
      wait_rst(1'b1, 10*RST, n);
      check(n == RST, "R7 pulse length", n, RST);
    end
    pulse_phase = 0;
    check(!wdo_seen_low, "R7 wdo_n high in pulse mode", int'(wdo_seen_low), 0);

    check(cmp_bad == 0, "R10 reset_hi complement", cmp_bad, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule